// File: doc/BRIEF.md
# Low-Resolution Framebuffer Scanout Scaler

This block drives a VGA-style raster from a small indexed-colour picture held in on-chip block RAM. Two counters walk the raster and produce horizontal and vertical sync, the two blanking flags and a display-enable flag. A pair of fractional steppers maps every visible screen position back to a source pixel. That pixel is fetched from a dual-port frame store, and its 6-bit value drives three 2-bit colour outputs. The horizontal stretch in the production geometry is 7.2, which is not a whole number, so a plain replication counter cannot do it. A stepper adds the source width on each visible pixel and moves to the next column each time the sum passes the active width. Rows use the same scheme.

A host-side loader writes the frame store through a separate address, data and enable port at any time, including while scanout runs. The production build sets a 1440x900 raster (1904 clocks per line, 932 lines per frame) and a 200x150 source. The defaults are a reduced geometry with the same 7.2 horizontal and 6 vertical ratios, which keeps the memory and one frame small.

Top module: `lowres_scanout`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low, from the first rising edge on, `vga_de` is 0, all colour bits are 0, `vga_hsync` is at its inactive level (1 with the default polarity), `vga_vsync` is at its inactive level (0 with the default polarity), and both blanking flags are 1. The first raster position after release is column 0, line 0.
- R2: A line lasts `H_ACT+H_FP+H_SW+H_BP` clocks. `vga_hblank` is 1 for raster columns h >= `H_ACT`. `vga_hsync` is active (low by default) for `H_ACT+H_FP` <= h < `H_ACT+H_FP+H_SW`.
- R3: A frame lasts `V_ACT+V_FP+V_SW+V_BP` lines. `vga_vblank` is 1 for raster lines v >= `V_ACT`. `vga_vsync` is active (high by default) for `V_ACT+V_FP` <= v < `V_ACT+V_FP+V_SW`.
- R4: `vga_de` is 1 exactly when neither blanking flag is 1. All colour outputs are 0 whenever `vga_de` is 0.
- R5: Visible column h shows source column floor(h*`SRC_W`/`H_ACT`).
- R6: Visible line v shows source row floor(v*`SRC_H`/`V_ACT`). In the production geometry each row repeats on exactly 6 lines.
- R7: Source pixel (row, col) is at frame-store address row*`SRC_W`+col. The stored word gives red in bits [5:4], green in bits [3:2] and blue in bits [1:0].
- R8: Every output shows raster position p two clock edges after the counters hold p. Sync, blank, enable and colour stay aligned to the same position.
- R9: A write with `wr_en` high and `wr_addr` < `SRC_W*SRC_H` stores `wr_data` at that rising edge. Reads at later edges return the new word. A read of the same address at the same edge returns the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Frame-store write strobe |
| wr_addr | input | $clog2(SRC_W*SRC_H) | Frame-store write address, row*SRC_W+col |
| wr_data | input | 6 | Pixel word, RRGGBB |
| vga_hsync | output | 1 | Horizontal sync (polarity by parameter) |
| vga_vsync | output | 1 | Vertical sync (polarity by parameter) |
| vga_hblank | output | 1 | Horizontal blanking flag |
| vga_vblank | output | 1 | Vertical blanking flag |
| vga_de | output | 1 | Display enable |
| vga_r | output | 2 | Red |
| vga_g | output | 2 | Green |
| vga_b | output | 2 | Blue |

## Verification
A host write and a scanout read can hit the same frame-store word in the same clock edge. The bench provokes this on purpose. On chosen cycles it aims the write at the exact address the scanout will fetch at the next edge, and it also issues random writes throughout the run. It judges the outcome with a reference model that delays each write by the two-edge pipeline. For the colliding pixel it expects the old word, and it expects the new word from the next fetch of that address onward.

// File: rtl/scan_pkg.sv
// Shared types for the scanout block.
// Assumes: a pixel is 6 bits, 2 bits per primary, red in the top pair.
package scan_pkg;
    typedef struct packed {
        logic [1:0] r;
        logic [1:0] g;
        logic [1:0] b;
    } rgb_t;

    localparam int PIX_W = $bits(rgb_t);
endpackage

// File: rtl/sync_axis.sv
// One raster axis: a position counter with active, blank and sync decode.
// Assumes: all four segment lengths are at least 1; step advances by one.
module sync_axis #(
    parameter int ACT  = 72,
    parameter int FP   = 4,
    parameter int SYNC = 8,
    parameter int BP   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic last,
    output logic active,
    output logic blank,
    output logic in_sync
);
    localparam int TOT = ACT + FP + SYNC + BP;
    localparam int CW  = $clog2(TOT);
    localparam int SYNC_LO = ACT + FP;
    localparam int SYNC_HI = ACT + FP + SYNC;

    logic [CW-1:0] cnt;

    // Position counter: advances on step, wraps after the last position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= last ? '0 : cnt + 1'b1;
    end

    // Segment decode of the current position.
    always_comb begin
        last    = (cnt == CW'(TOT - 1));
        active  = (cnt < CW'(ACT));
        blank   = !(cnt < CW'(ACT));
        in_sync = (cnt >= CW'(SYNC_LO)) && (cnt < CW'(SYNC_HI));
    end

    // R2 (R3 on the vertical instance): counter returns to zero after the last position
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (cnt == '0));

    // R2 (R3 on the vertical instance): sync pulse lies inside blanking
    p_sync_in_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_sync |-> blank);
endmodule

// File: rtl/ratio_stepper.sv
// Fractional index stepper: idx = floor(n*NUM/DEN) after n advances.
// Assumes: NUM < DEN (upscaling), restart has priority over advance.
module ratio_stepper #(
    parameter int NUM = 10,
    parameter int DEN = 72,
    parameter int IW  = $clog2(NUM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          advance,
    output logic [IW-1:0] idx
);
    localparam int AW = $clog2(DEN) + 1;

    logic [AW-1:0] acc;
    logic [AW-1:0] sum;
    logic          wrap;

    // Remainder plus one step, and whether it passes the denominator.
    always_comb begin
        sum  = acc + AW'(NUM);
        wrap = (sum >= AW'(DEN));
    end

    // Accumulator and index update.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc <= '0;
            idx <= '0;
        end else if (advance) begin
            acc <= wrap ? sum - AW'(DEN) : sum;
            idx <= wrap ? idx + 1'b1 : idx;
        end
    end

    // R5: one advance moves the index by at most one
    p_step_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart) |=> (idx == $past(idx) || idx == $past(idx) + 1'b1));

    // R6: a restart brings the index back to zero
    p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (idx == '0));
endmodule

// File: rtl/frame_store.sv
// Dual-port pixel memory: one write port for the loader, one read port for scanout.
// Assumes: one clock; a read of the word written at the same edge returns the old word.
module frame_store #(
    parameter int DEPTH = 50,
    parameter int DW    = 6,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Write port: in-range writes only.
    always_ff @(posedge clk) begin
        if (we && ({1'b0, waddr} < (AW+1)'(DEPTH)))
            mem[waddr] <= wdata;
    end

    // Registered read port, old data on a same-edge collision.
    always_ff @(posedge clk) begin
        if ({1'b0, raddr} < (AW+1)'(DEPTH))
            rdata <= mem[raddr];
        else
            rdata <= '0;
    end
endmodule

// File: rtl/lowres_scanout.sv
// Scanout of a small framebuffer onto a larger raster with fractional scaling.
// Assumes: SRC_W < H_ACT and SRC_H < V_ACT; outputs lag the counters by two edges.
module lowres_scanout #(
    parameter int H_ACT = 72,
    parameter int H_FP  = 4,
    parameter int H_SW  = 8,
    parameter int H_BP  = 12,
    parameter int V_ACT = 30,
    parameter int V_FP  = 1,
    parameter int V_SW  = 3,
    parameter int V_BP  = 4,
    parameter int SRC_W = 10,
    parameter int SRC_H = 5,
    parameter bit HS_ACT_LOW = 1'b1,
    parameter bit VS_ACT_LOW = 1'b0,
    localparam int DEPTH = SRC_W * SRC_H,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [5:0]    wr_data,
    output logic          vga_hsync,
    output logic          vga_vsync,
    output logic          vga_hblank,
    output logic          vga_vblank,
    output logic          vga_de,
    output logic [1:0]    vga_r,
    output logic [1:0]    vga_g,
    output logic [1:0]    vga_b
);
    import scan_pkg::*;

    localparam int CW = $clog2(SRC_W + 1);
    localparam int RW = $clog2(SRC_H + 1);

    logic h_last, h_act, h_blank, h_sync;
    logic v_last, v_act, v_blank, v_sync;
    logic [CW-1:0] col;
    logic [RW-1:0] row;
    logic          pix_active;
    logic [AW-1:0] rd_addr;
    rgb_t          rd_pix;
    logic s1_act, s1_hb, s1_vb, s1_hs, s1_vs;

    sync_axis #(.ACT(H_ACT), .FP(H_FP), .SYNC(H_SW), .BP(H_BP)) u_haxis (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .last(h_last), .active(h_act), .blank(h_blank), .in_sync(h_sync));

    sync_axis #(.ACT(V_ACT), .FP(V_FP), .SYNC(V_SW), .BP(V_BP)) u_vaxis (
        .clk(clk), .rst_n(rst_n), .step(h_last),
        .last(v_last), .active(v_act), .blank(v_blank), .in_sync(v_sync));

    ratio_stepper #(.NUM(SRC_W), .DEN(H_ACT), .IW(CW)) u_col (
        .clk(clk), .rst_n(rst_n), .restart(h_last), .advance(h_act), .idx(col));

    ratio_stepper #(.NUM(SRC_H), .DEN(V_ACT), .IW(RW)) u_row (
        .clk(clk), .rst_n(rst_n), .restart(h_last && v_last),
        .advance(h_last && v_act), .idx(row));

    // Fetch address for the current raster position, parked at zero in blanking.
    always_comb begin
        pix_active = h_act && v_act;
        rd_addr    = pix_active ? AW'(row) * AW'(SRC_W) + AW'(col) : '0;
    end

    frame_store #(.DEPTH(DEPTH), .DW(PIX_W), .AW(AW)) u_store (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(rd_pix));

    // Stage 1: hold timing flags for the read latency of the frame store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_act <= 1'b0;
            s1_hb  <= 1'b1;
            s1_vb  <= 1'b1;
            s1_hs  <= 1'b0;
            s1_vs  <= 1'b0;
        end else begin
            s1_act <= pix_active;
            s1_hb  <= h_blank;
            s1_vb  <= v_blank;
            s1_hs  <= h_sync;
            s1_vs  <= v_sync;
        end
    end

    // Stage 2: output registers with polarity and colour masking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vga_hsync  <= HS_ACT_LOW;
            vga_vsync  <= VS_ACT_LOW;
            vga_hblank <= 1'b1;
            vga_vblank <= 1'b1;
            vga_de     <= 1'b0;
            vga_r      <= '0;
            vga_g      <= '0;
            vga_b      <= '0;
        end else begin
            vga_hsync  <= s1_hs ^ HS_ACT_LOW;
            vga_vsync  <= s1_vs ^ VS_ACT_LOW;
            vga_hblank <= s1_hb;
            vga_vblank <= s1_vb;
            vga_de     <= s1_act;
            vga_r      <= s1_act ? rd_pix.r : 2'b00;
            vga_g      <= s1_act ? rd_pix.g : 2'b00;
            vga_b      <= s1_act ? rd_pix.b : 2'b00;
        end
    end

    // R4: enable only outside both blanking intervals
    p_de_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vga_de |-> (!vga_hblank && !vga_vblank));

    // R7: visible positions always fetch inside the frame store
    p_addr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_active |-> ({1'b0, rd_addr} < (AW+1)'(DEPTH)));
endmodule

// File: tb/test_lowres_scanout.sv
module test_lowres_scanout;
    localparam int HA = 72, HFP = 4, HSW = 8, HBP = 12;
    localparam int VA = 30, VFP = 1, VSW = 3, VBP = 4;
    localparam int SW = 10, SH = 5;
    localparam int HT = HA + HFP + HSW + HBP;
    localparam int VT = VA + VFP + VSW + VBP;
    localparam int DEPTH = SW * SH;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n;
    logic wr_en;
    logic [AW-1:0] wr_addr;
    logic [5:0] wr_data;
    logic hs, vs, hb, vb, de;
    logic [1:0] r, g, b;

    int n_cmp = 0;
    int n_bad = 0;
    int collisions = 0;
    bit done = 0;
    logic [5:0] model [DEPTH];
    bit pend_v;
    int pend_a;
    logic [5:0] pend_d;

    always #5 clk = ~clk;

    lowres_scanout i_lowres_scanout (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vga_hsync(hs), .vga_vsync(vs), .vga_hblank(hb), .vga_vblank(vb), .vga_de(de),
        .vga_r(r), .vga_g(g), .vga_b(b));

    function automatic int pos_h(int p); return p % HT; endfunction
    function automatic int pos_v(int p); return (p / HT) % VT; endfunction
    function automatic bit pos_act(int p);
        return (pos_h(p) < HA) && (pos_v(p) < VA);
    endfunction
    function automatic int src_addr(int p);
        return ((pos_v(p) * SH) / VA) * SW + (pos_h(p) * SW) / HA;
    endfunction

    task automatic chk(string tag, int act, int exp, int p);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s pos=%0d actual=%0h expected=%0h", tag, p, act, exp);
        end
    endtask

    // R1: idle output state
    task automatic chk_idle();
        chk("R1 hsync", hs, 1, -1);
        chk("R1 vsync", vs, 0, -1);
        chk("R1 hblank", hb, 1, -1);
        chk("R1 vblank", vb, 1, -1);
        chk("R1 de", de, 0, -1);
        chk("R1 colour", {r, g, b}, 0, -1);
    endtask

    task automatic chk_pixel(int p);
        int h = pos_h(p);
        int v = pos_v(p);
        bit act = pos_act(p);
        logic [5:0] px = act ? model[src_addr(p)] : 6'd0;
        chk("R2 R8 hsync", hs, !((h >= HA + HFP) && (h < HA + HFP + HSW)), p);
        chk("R2 hblank", hb, h >= HA, p);
        chk("R3 vsync", vs, (v >= VA + VFP) && (v < VA + VFP + VSW), p);
        chk("R3 vblank", vb, v >= VA, p);
        chk("R4 R8 de", de, act, p);
        // R5, R6 mapping; R7 packing; R9 write visibility and collision order
        chk("R5 R6 R7 R9 red", r, px[5:4], p);
        chk("R5 R6 R7 R9 green", g, px[3:2], p);
        chk("R5 R6 R7 R9 blue", b, px[1:0], p);
    endtask

    task automatic run(int cycles);
        rst_n = 1'b1;
        pend_v = 0;
        for (int n = 1; n <= cycles; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == 1) chk_idle();
            else chk_pixel(n - 2);
            if (pend_v) model[pend_a] = pend_d;
            pend_v = wr_en;
            pend_a = int'(wr_addr);
            pend_d = wr_data;
            // Next edge fetches raster position n.
            if ((n % 53 == 0) && pos_act(n)) begin
                wr_en = 1'b1;
                wr_addr = AW'(src_addr(n));
                wr_data = model[src_addr(n)] ^ 6'h2A;
                collisions++;
            end else if ($urandom % 6 == 0) begin
                wr_en = 1'b1;
                wr_addr = AW'($urandom % DEPTH);
                wr_data = 6'($urandom);
            end else begin
                wr_en = 1'b0;
            end
        end
    endtask

    task automatic mid_reset();
        if (pend_v) model[pend_a] = pend_d;
        if (wr_en) model[int'(wr_addr)] = wr_data;
        pend_v = 0;
        rst_n = 1'b0;
        wr_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk_idle();
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        wr_en = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        @(negedge clk);
        // Preload through the write port while reset holds the raster.
        for (int a = 0; a < DEPTH; a++) begin
            wr_en = 1'b1;
            wr_addr = AW'(a);
            wr_data = (a == 0) ? 6'h3F : 6'($urandom);
            model[a] = wr_data;
            @(negedge clk);
            chk_idle();
        end
        wr_en = 1'b0;
        @(negedge clk);
        chk_idle();
        run(2 * HT * VT + 700);
        mid_reset();
        run(HT * VT + HT * 3 + 17);
        wr_en = 1'b0;
        if (collisions == 0) chk("R9 collisions provoked", 0, 1, -1);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule